// File: doc/BRIEF.md
# Parallel CPU-Interface Panel Writer

This block sends one frame of pixel words to a display panel that keeps its own frame memory. The panel sits on an 8080-style parallel bus with an active-low chip select and an active-low write strobe. Each pixel word is taken from a valid/ready stream and placed on the data bus. The word is then written with four phase lengths, and all four come from one packed timing word. Chip select stays low for the whole frame and is released after the last word.

A frame can start in two ways. In software mode a command bit starts it directly. In hardware mode the command only marks an update as pending, and the next rising edge of the panel's tearing-effect (TE) line starts the frame. While a frame is in flight, any further start request is dropped, because a repeated start can reset the panel. When a frame ends, the block gives a one-cycle frame-done pulse and sets a sticky status bit, which is cleared by writing 1 to it.

The write clock is chosen at twice the pixel rate, so that a whole frame fits between two TE pulses. With no timing programmed, the usual setting is chip-select setup 0, write setup 0, write active 1 and write hold 0, with the enable bit set.

Top module: `smart_panel_writer`

## Requirements
- R1: After reset, and at any time no frame is in flight: `lcd_cs_n` = 1, `lcd_wr_n` = 1, `pix_ready` = 0, `frame_done` = 0. `irq_stat` resets to 0.
- R2: The timing word `cfg_word` holds the phase lengths in fixed fields: chip-select setup in [19:16], write setup in [15:12], write active in [11:8] and write hold in [7:4]. Bit 0 enables the interface; while it is 0, no frame starts.
- R3: For each word, `lcd_wr_n` falls 1 + CSS + WRS cycles after the word's fetch cycle begins, where CSS is the chip-select setup and WRS the write setup. `lcd_wr_n` is only ever low while `lcd_cs_n` is low.
- R4: `lcd_wr_n` stays low for the write-active count of cycles; a count of 0 gives 1 cycle.
- R5: After `lcd_wr_n` rises, the write-hold count of cycles passes before the next word's fetch cycle. For the last word, `lcd_cs_n` rises exactly that many cycles after `lcd_wr_n` rises.
- R6: `lcd_data` carries the accepted pixel word and does not change while `lcd_wr_n` is low or in the cycle it rises.
- R7: `pix_ready` is high only in a fetch cycle, with chip select low and write high. While `pix_valid` is low the transfer waits, and no write strobe occurs. Words go out in stream order.
- R8: A frame writes exactly `frame_words` words (the value sampled at start) and then raises `lcd_cs_n`. A `frame_words` value of 0 starts nothing.
- R9: Software mode (`trig_ctrl[0]` = 1): a rising edge of `trig_ctrl[1]` starts a frame.
- R10: Hardware mode (`trig_ctrl[0]` = 0, `trig_ctrl[3]` = 1): a rising edge of `trig_ctrl[1]` marks an update pending. A rising edge of `te_in` starts a frame only if an update is pending and the mask bit `trig_ctrl[4]` is 0. A masked edge leaves the pending update in place. A started frame clears it.
- R11: In hardware mode with `trig_ctrl[31]` = 1, every unmasked `te_in` rising edge starts a frame, even with no update pending.
- R12: A start request that arrives while a frame is in flight is dropped and is not queued.
- R13: `frame_done` is a one-cycle pulse in the cycle `lcd_cs_n` rises. It sets `irq_stat` on the next cycle. A pulse on `irq_clr` clears `irq_stat`; if both happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 32 | Packed phase lengths and interface enable |
| trig_ctrl | input | 32 | Start control: mode, command, hardware enable, mask, per-TE |
| te_in | input | 1 | Tearing-effect input from the panel |
| frame_words | input | FW | Number of words in a frame |
| pix_data | input | DW | Pixel stream data |
| pix_valid | input | 1 | Pixel stream valid |
| pix_ready | output | 1 | Pixel stream ready |
| irq_clr | input | 1 | Write-1 clear of the frame-done status |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_wr_n | output | 1 | Panel write strobe, active low |
| lcd_data | output | DW | Panel data bus |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| irq_stat | output | 1 | Sticky frame-done status |

## Verification
The bench measures each phase by counting cycles at the bus pins, and checks zero-length phases and the write-active count of 0. A design that did not skip a zero phase, or that gave no strobe for an active count of 0, would show the wrong lead-in or strobe width. A second start pulse is sent in the middle of a frame. A design that queued it would send a second, unasked frame after the first one ends. In hardware mode, TE edges arrive with no update pending, while masked, after the mask is lifted, and after the pending update has been used. A design that lost the pending update at a masked edge, or kept it after a start, would give one frame too few or too many.

// File: rtl/spw_pkg.sv
package spw_pkg;

  localparam int PH_W = 4;

  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_HOLD_LSB = 4;
  localparam int CFG_ACT_LSB  = 8;
  localparam int CFG_WRS_LSB  = 12;
  localparam int CFG_CSS_LSB  = 16;

  localparam int TRG_SW_MODE = 0;
  localparam int TRG_CMD     = 1;
  localparam int TRG_HW_EN   = 3;
  localparam int TRG_HW_MASK = 4;
  localparam int TRG_PER_TE  = 31;

  // active = 1, all other phases 0, interface enabled
  localparam logic [31:0] CFG_DEFAULT = 32'h0000_0101;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CSS, ST_WRS, ST_WRA, ST_WRH, ST_FIN
  } wr_state_e;

  typedef struct packed {
    logic [PH_W-1:0] cs_setup;
    logic [PH_W-1:0] wr_setup;
    logic [PH_W-1:0] wr_active;
    logic [PH_W-1:0] wr_hold;
  } wr_timing_t;

  function automatic wr_timing_t unpack_timing(input logic [31:0] w);
    wr_timing_t t;
    t.cs_setup  = w[CFG_CSS_LSB  +: PH_W];
    t.wr_setup  = w[CFG_WRS_LSB  +: PH_W];
    t.wr_active = w[CFG_ACT_LSB  +: PH_W];
    t.wr_hold   = w[CFG_HOLD_LSB +: PH_W];
    return t;
  endfunction

  // number of cycles a phase lasts once entered (never zero)
  function automatic logic [PH_W-1:0] phase_len(input wr_state_e st, input wr_timing_t t);
    case (st)
      ST_CSS:  return t.cs_setup;
      ST_WRS:  return t.wr_setup;
      ST_WRA:  return (t.wr_active == '0) ? PH_W'(1) : t.wr_active;
      ST_WRH:  return t.wr_hold;
      default: return PH_W'(1);
    endcase
  endfunction

  // phase that follows st, skipping phases of zero length
  function automatic wr_state_e next_phase(input wr_state_e st, input wr_timing_t t,
                                           input logic last_word);
    case (st)
      ST_IDLE:  return ST_FETCH;
      ST_FETCH: return (t.cs_setup != '0) ? ST_CSS :
                       (t.wr_setup != '0) ? ST_WRS : ST_WRA;
      ST_CSS:   return (t.wr_setup != '0) ? ST_WRS : ST_WRA;
      ST_WRS:   return ST_WRA;
      ST_WRA:   return (t.wr_hold != '0) ? ST_WRH : (last_word ? ST_FIN : ST_FETCH);
      ST_WRH:   return last_word ? ST_FIN : ST_FETCH;
      default:  return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/spw_launch.sv
module spw_launch
  import spw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        if_en,
  input  logic        frame_nz,
  input  logic        busy,
  input  logic [31:0] trig_ctrl,
  input  logic        te_in,
  output logic        launch,
  output logic        pending
);

  logic cmd_q, te_q, pend_q;
  logic cmd_rise, te_rise, sw_mode, hw_mode, sw_go, hw_go, can_go;
  logic unused_trig;

  assign unused_trig = ^{trig_ctrl[30:5], trig_ctrl[2]};

  assign cmd_rise = trig_ctrl[TRG_CMD] & ~cmd_q;
  assign te_rise  = te_in & ~te_q;
  assign sw_mode  = trig_ctrl[TRG_SW_MODE];
  assign hw_mode  = ~sw_mode & trig_ctrl[TRG_HW_EN];

  assign sw_go  = sw_mode & cmd_rise;
  assign hw_go  = hw_mode & te_rise & ~trig_ctrl[TRG_HW_MASK] &
                  (pend_q | trig_ctrl[TRG_PER_TE]);
  assign can_go = if_en & frame_nz & ~busy;
  assign launch = can_go & (sw_go | hw_go);
  assign pending = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= 1'b0;
      te_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cmd_q <= trig_ctrl[TRG_CMD];
      te_q  <= te_in;
      if (launch && hw_go)
        pend_q <= 1'b0;
      else if (hw_mode && cmd_rise)
        pend_q <= 1'b1;
    end
  end

endmodule

// File: rtl/spw_strobe.sv
module spw_strobe
  import spw_pkg::*;
#(
  parameter int DW = 16,
  parameter int FW = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  wr_timing_t    timing_in,
  input  logic [FW-1:0] frame_words,
  input  logic [DW-1:0] pix_data,
  input  logic          pix_valid,
  output logic          pix_ready,
  output logic          cs_n,
  output logic          wr_n,
  output logic [DW-1:0] bus_data,
  output logic          busy,
  output logic          done,
  output logic          word_end
);

  wr_state_e       state, state_n;
  wr_timing_t      tim_q;
  logic [PH_W-1:0] cnt;
  logic [FW-1:0]   left;
  logic [DW-1:0]   data_q;
  logic            adv, last_word;

  assign last_word = (left == FW'(1));

  always_comb begin
    adv     = 1'b0;
    state_n = state;
    case (state)
      ST_IDLE:  if (launch) state_n = ST_FETCH;
      ST_FETCH: adv = pix_valid;
      ST_CSS, ST_WRS, ST_WRA, ST_WRH: adv = (cnt == '0);
      ST_FIN:   adv = 1'b1;
      default:  state_n = ST_IDLE;
    endcase
    if (adv) state_n = next_phase(state, tim_q, last_word);
  end

  assign word_end = adv && (state_n == ST_FETCH || state_n == ST_FIN) && state != ST_FIN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      tim_q  <= '0;
      left   <= '0;
      data_q <= '0;
    end else begin
      state <= state_n;
      if (state_n != state)
        cnt <= phase_len(state_n, tim_q) - PH_W'(1);
      else if (cnt != '0)
        cnt <= cnt - PH_W'(1);
      if (state == ST_IDLE && launch) begin
        tim_q <= timing_in;
        left  <= frame_words;
      end else if (word_end) begin
        left <= left - FW'(1);
      end
      if (state == ST_FETCH && pix_valid)
        data_q <= pix_data;
    end
  end

  assign pix_ready = (state == ST_FETCH);
  assign cs_n      = (state == ST_IDLE) || (state == ST_FIN);
  assign wr_n      = (state != ST_WRA);
  assign bus_data  = data_q;
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);

endmodule

// File: rtl/smart_panel_writer.sv
module smart_panel_writer
  import spw_pkg::*;
#(
  parameter int DW = 16,
  parameter int FW = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   cfg_word,
  input  logic [31:0]   trig_ctrl,
  input  logic          te_in,
  input  logic [FW-1:0] frame_words,
  input  logic [DW-1:0] pix_data,
  input  logic          pix_valid,
  output logic          pix_ready,
  input  logic          irq_clr,
  output logic          lcd_cs_n,
  output logic          lcd_wr_n,
  output logic [DW-1:0] lcd_data,
  output logic          frame_done,
  output logic          irq_stat
);

  wr_timing_t tim_w;
  logic       en_w, launch_w, busy_w, done_w, word_end_w, pend_w;
  logic       unused_cfg;

  assign tim_w      = unpack_timing(cfg_word);
  assign en_w       = cfg_word[CFG_EN_BIT];
  assign unused_cfg = ^{cfg_word[31:20], cfg_word[3:1], word_end_w, pend_w};

  spw_launch u_launch (
    .clk       (clk),
    .rst_n     (rst_n),
    .if_en     (en_w),
    .frame_nz  (frame_words != '0),
    .busy      (busy_w),
    .trig_ctrl (trig_ctrl),
    .te_in     (te_in),
    .launch    (launch_w),
    .pending   (pend_w)
  );

  spw_strobe #(.DW(DW), .FW(FW)) u_strobe (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch_w),
    .timing_in   (tim_w),
    .frame_words (frame_words),
    .pix_data    (pix_data),
    .pix_valid   (pix_valid),
    .pix_ready   (pix_ready),
    .cs_n        (lcd_cs_n),
    .wr_n        (lcd_wr_n),
    .bus_data    (lcd_data),
    .busy        (busy_w),
    .done        (done_w),
    .word_end    (word_end_w)
  );

  assign frame_done = done_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq_stat <= 1'b0;
    else if (done_w)
      irq_stat <= 1'b1;
    else if (irq_clr)
      irq_stat <= 1'b0;
  end

endmodule

// File: rtl/spw_checker.sv
module spw_checker #(
  parameter int DW = 16
)(
  input logic          clk,
  input logic          rst_n,
  input logic          launch,
  input logic          busy,
  input logic          cs_n,
  input logic          wr_n,
  input logic [DW-1:0] data,
  input logic          pix_ready,
  input logic          frame_done,
  input logic          irq_stat
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && wr_n && !pix_ready && !frame_done)); // R1
  AST_WR_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n); // R3
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> $stable(data)); // R6
  AST_DATA_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> $stable(data)); // R6
  AST_READY_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (!cs_n && wr_n)); // R7
  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> frame_done); // R8
  AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy); // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R13
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> irq_stat); // R13

endmodule

bind smart_panel_writer spw_checker #(.DW(DW)) u_spw_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .launch     (launch_w),
  .busy       (busy_w),
  .cs_n       (lcd_cs_n),
  .wr_n       (lcd_wr_n),
  .data       (lcd_data),
  .pix_ready  (pix_ready),
  .frame_done (frame_done),
  .irq_stat   (irq_stat)
);

// File: tb/test_smart_panel_writer.sv
`timescale 1ns/1ps
module test_smart_panel_writer;
  import spw_pkg::*;

  localparam int DW = 16;
  localparam int FW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   cfg_word = '0;
  logic [31:0]   trig_ctrl = '0;
  logic          te_in = 1'b0;
  logic [FW-1:0] frame_words = '0;
  logic [DW-1:0] pix_data;
  logic          pix_valid = 1'b1;
  logic          pix_ready;
  logic          irq_clr = 1'b0;
  logic          lcd_cs_n, lcd_wr_n, frame_done, irq_stat;
  logic [DW-1:0] lcd_data;

  int n_chk = 0, n_err = 0, cyc = 0;
  int idx = 0, idx0 = 0, seed = 0;
  bit acc = 0, prev_cs = 1, prev_wr = 1, finished = 0;
  int nwr = 0, lead = 0, cur_w = 0, last_w = 0, since_rise = 0, hold_meas = 0;
  int done_w = 0, frames_started = 0, frames_done = 0;
  logic [DW-1:0] cap [0:15];

  always #2 clk = ~clk;

  assign pix_data = DW'(seed + idx);

  smart_panel_writer #(.DW(DW), .FW(FW)) i_smart_panel_writer (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .trig_ctrl(trig_ctrl),
    .te_in(te_in), .frame_words(frame_words), .pix_data(pix_data),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .irq_clr(irq_clr),
    .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n), .lcd_data(lcd_data),
    .frame_done(frame_done), .irq_stat(irq_stat)
  );

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // bus monitor, sampling between clock edges
  always @(negedge clk) begin
    cyc++;
    if (acc) idx++;
    acc = pix_ready && pix_valid;
    if (rst_n) begin
      if (!lcd_cs_n && prev_cs) begin
        frames_started++; nwr = 0; lead = 0; done_w = 0; idx0 = idx;
      end
      if (!lcd_wr_n) begin
        if (prev_wr) begin cur_w = 0; if (nwr < 16) cap[nwr] = lcd_data; end
        cur_w++;
      end else if (!prev_wr) begin
        last_w = cur_w; nwr++; since_rise = lcd_cs_n ? 0 : 1;
      end else if (!lcd_cs_n && nwr > 0) begin
        since_rise++;
      end
      if (!lcd_cs_n && lcd_wr_n && nwr == 0) lead++;
      if (lcd_cs_n && !prev_cs) hold_meas = since_rise;
      if (frame_done) begin done_w++; frames_done++; end
    end
    prev_cs = lcd_cs_n;
    prev_wr = lcd_wr_n;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input int css, input int wrs, input int act,
                                         input int hold, input bit en);
    return {12'h0, 4'(css), 4'(wrs), 4'(act), 4'(hold), 3'b0, en};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_cmd();
    @(negedge clk); trig_ctrl[1] = 1'b1;
    @(negedge clk); trig_ctrl[1] = 1'b0;
  endtask

  task automatic pulse_te();
    @(negedge clk); te_in = 1'b1;
    idle(2); te_in = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int d0 = frames_done;
    int t = 0;
    while (frames_done == d0 && t < 3000) begin @(negedge clk); t++; end
    chk({req, " frame completes"}, int'(frames_done > d0), 1);
    idle(2);
  endtask

  task automatic check_frame(input string req, input int n, input int css, input int wrs,
                             input int act, input int hold);
    chk({req, " word count"}, nwr, n);
    chk({req, " lead-in cycles"}, lead, 1 + css + wrs);
    chk({req, " strobe width"}, last_w, (act == 0) ? 1 : act);
    chk({req, " hold before CS release"}, hold_meas, hold);
    chk({req, " done pulse width"}, done_w, 1);
    for (int k = 0; k < n && k < 16; k++)
      chk({req, " data word"}, int'(cap[k]), int'(DW'(seed + idx0 + k)));
  endtask

  task automatic sw_frame(input string req, input int n, input int css, input int wrs,
                          input int act, input int hold);
    cfg_word = mk_cfg(css, wrs, act, hold, 1'b1);
    frame_words = FW'(n);
    trig_ctrl = 32'h1;
    pulse_cmd();
    wait_done(req);
    check_frame(req, n, css, wrs, act, hold);
  endtask

  task automatic t_reset();
    chk("R1 cs_n at reset", int'(lcd_cs_n), 1);
    chk("R1 wr_n at reset", int'(lcd_wr_n), 1);
    chk("R1 ready at reset", int'(pix_ready), 0);
    chk("R1 done at reset", int'(frame_done), 0);
    chk("R1 irq at reset", int'(irq_stat), 0);
  endtask

  task automatic t_default();
    seed = 16'h1000;
    cfg_word = CFG_DEFAULT;
    frame_words = FW'(4);
    trig_ctrl = 32'h1;
    pulse_cmd();
    wait_done("R9 default timing");
    check_frame("R9 R8 default", 4, 0, 0, 1, 0);
  endtask

  task automatic t_phases();
    seed = 16'h2200;
    sw_frame("R2 R3 R5 phases", 3, 2, 3, 4, 5);
    seed = 16'h2300;
    sw_frame("R3 R5 cs setup only", 2, 6, 0, 2, 1);
  endtask

  task automatic t_zero_active();
    seed = 16'h3300;
    sw_frame("R4 active zero", 2, 1, 0, 0, 2);
  endtask

  task automatic t_disabled();
    int f0 = frames_started;
    cfg_word = mk_cfg(0, 0, 1, 0, 1'b0);
    frame_words = FW'(2);
    trig_ctrl = 32'h1;
    pulse_cmd();
    idle(30);
    chk("R2 disabled interface starts no frame", frames_started - f0, 0);
    chk("R2 disabled cs_n stays high", int'(lcd_cs_n), 1);
  endtask

  task automatic t_zero_words();
    int f0 = frames_started;
    cfg_word = CFG_DEFAULT;
    frame_words = '0;
    trig_ctrl = 32'h1;
    pulse_cmd();
    idle(30);
    chk("R8 zero frame size starts nothing", frames_started - f0, 0);
  endtask

  task automatic t_retrigger();
    int f0 = frames_started;
    seed = 16'h4400;
    cfg_word = mk_cfg(3, 3, 3, 3, 1'b1);
    frame_words = FW'(4);
    trig_ctrl = 32'h1;
    pulse_cmd();
    idle(10);
    pulse_cmd();
    wait_done("R12 busy retrigger");
    check_frame("R12 first frame", 4, 3, 3, 3, 3);
    idle(80);
    chk("R12 mid-frame request dropped", frames_started - f0, 1);
  endtask

  task automatic t_hw();
    int f0;
    seed = 16'h5500;
    cfg_word = mk_cfg(1, 1, 2, 1, 1'b1);
    frame_words = FW'(3);
    trig_ctrl = 32'h8;
    f0 = frames_started;
    pulse_te();
    idle(20);
    chk("R10 TE without pending update", frames_started - f0, 0);
    pulse_cmd();
    trig_ctrl[4] = 1'b1;
    pulse_te();
    idle(20);
    chk("R10 masked TE", frames_started - f0, 0);
    trig_ctrl[4] = 1'b0;
    pulse_te();
    wait_done("R10 unmasked TE");
    chk("R10 pending update launches", frames_started - f0, 1);
    check_frame("R10 hw frame", 3, 1, 1, 2, 1);
    pulse_te();
    idle(30);
    chk("R10 pending cleared by launch", frames_started - f0, 1);
  endtask

  task automatic t_per_te();
    int f0 = frames_started;
    seed = 16'h6600;
    cfg_word = CFG_DEFAULT;
    frame_words = FW'(2);
    trig_ctrl = 32'h8000_0008;
    pulse_te();
    wait_done("R11 first TE");
    pulse_te();
    wait_done("R11 second TE");
    chk("R11 one frame per TE", frames_started - f0, 2);
    check_frame("R11 per-TE frame", 2, 0, 0, 1, 0);
  endtask

  task automatic t_stall();
    int strobes = 0;
    seed = 16'h7700;
    cfg_word = CFG_DEFAULT;
    frame_words = FW'(3);
    trig_ctrl = 32'h1;
    pix_valid = 1'b0;
    pulse_cmd();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!lcd_wr_n) strobes++;
    end
    chk("R7 no strobe while stream stalls", strobes, 0);
    chk("R7 cs held during stall", int'(lcd_cs_n), 0);
    pix_valid = 1'b1;
    wait_done("R7 stalled frame");
    chk("R7 word count", nwr, 3);
    for (int k = 0; k < 3; k++)
      chk("R7 stream order", int'(cap[k]), int'(DW'(seed + idx0 + k)));
  endtask

  task automatic t_irq();
    chk("R13 status set after frame", int'(irq_stat), 1);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk("R13 status cleared by write 1", int'(irq_stat), 0);
  endtask

  initial begin
    idle(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    t_reset();
    t_default();
    t_irq();
    t_phases();
    t_zero_active();
    t_disabled();
    t_zero_words();
    t_retrigger();
    t_hw();
    t_per_te();
    t_stall();
    t_irq();
    idle(5);
    finish_run();
  end

endmodule